// File: doc/BRIEF.md
# Address Translation Cache with Address-Space Tags and Pinned Entries

This block is a small, fully associative cache of recent translations from virtual page numbers to physical frame numbers. A lookup carries a virtual page number, the identifier of the running address space and an access type. In the same cycle the block returns hit or miss, the stored frame number and a protection-fault flag. A miss tells an external page-table walker to fetch the mapping. The walker then writes the result back through the refill port, and the write takes effect on the next clock edge.

Every entry carries an address-space tag, so translations for several processes can live side by side. An entry can also be marked global, which makes it match any address space. Entries can be pinned, for example to hold kernel mappings. Pinned entries are never picked as replacement victims, and a flush does not remove them.

A flush issued at a context switch removes every entry that is not pinned. When the cache is full, a round-robin pointer picks the victim and steps over pinned entries. If every entry is pinned, the refill is dropped and an error flag is raised.

Top module: `tlb_top`

## Requirements
- R1: While `lk_req` is high and a valid entry matches the lookup, `lk_hit` is high and `lk_pfn` shows that entry's frame number in the same cycle. With `lk_req` high and no match, `lk_miss` is high. With `lk_req` low, `lk_hit`, `lk_miss` and `lk_fault` are all low. `lk_pfn` is zero whenever `lk_hit` is low.
- R2: An entry that is not global matches only when its stored address-space tag equals `lk_asid`. A global entry matches for any value of `lk_asid`.
- R3: An entry whose valid bit is clear never matches. Reset clears every valid bit and sets the replacement pointer to 0.
- R4: The permission field `rf_perm` uses bit 0 for read, bit 1 for write and bit 2 for execute. `lk_acc` uses 0 for read, 1 for write, 2 for execute and 3 as a reserved code. On a hit, `lk_fault` is high when the permission bit for the requested access is clear, or when the access code is 3. The hit and the frame number are still reported.
- R5: A refill whose page number and address-space tag equal those of a valid entry overwrites that entry in place. Otherwise it goes into the lowest-indexed invalid slot. The new contents are visible to lookups from the next cycle on.
- R6: If a refill finds no matching entry and no free slot, it replaces the first unpinned entry found by searching upward from the replacement pointer, wrapping at the last slot. The pointer then moves to the slot after the victim. The pointer does not move on in-place updates or free-slot fills.
- R7: If a refill finds no matching entry, no free slot and no unpinned entry, it is dropped and the cache is unchanged. `rf_err` is high for exactly the cycle after that refill.
- R8: A flush clears every unpinned entry at the next edge, and pinned entries stay valid. If a refill arrives in the same cycle as a flush, the refill picks its slot from the contents before the flush, and the refilled entry survives.
- R9: When several valid entries match one lookup, the lowest-indexed one supplies the frame number and the permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup requested and not found; asks the walker for a fetch |
| lk_pfn | output | 20 | Frame number of the matching entry, zero without a hit |
| lk_fault | output | 1 | Hit whose permissions forbid the access |
| rf_en | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_asid | input | 8 | Refill address-space tag |
| rf_pfn | input | 20 | Refill frame number |
| rf_perm | input | 3 | Refill permissions: bit 0 read, bit 1 write, bit 2 execute |
| rf_global | input | 1 | Refill entry matches every address space |
| rf_wired | input | 1 | Refill entry is pinned |
| fl_en | input | 1 | Flush the unpinned entries |
| rf_err | output | 1 | Previous-cycle refill was dropped because every entry is pinned |

## Verification
Some properties are checked by assertions on every cycle. A fault never appears without a hit. Hit and miss never appear together, and neither appears without a request. A replacement victim is never a pinned entry. After a flush with no refill, no unpinned entry is still valid, and every pinned entry that was valid stays valid. A raised `rf_err` implies every entry was valid and pinned. Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model on every cycle: the exact frame numbers returned, the round-robin order that skips pinned slots, in-place updates, the lowest-index rule when several entries match, and a flush and refill arriving in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int TLB_ENTRIES = 8;
    localparam int VPN_W       = 20;
    localparam int ASID_W      = 8;
    localparam int PFN_W       = 20;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic              wired;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        perm_t             perm;
    } tlb_entry_t;

    function automatic logic perm_allows(perm_t p, acc_e a);
        logic ok;
        case (a)
            ACC_READ:  ok = p.r;
            ACC_WRITE: ok = p.w;
            ACC_EXEC:  ok = p.x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int N = TLB_ENTRIES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  tlb_entry_t [N-1:0]       ent,
    input  logic                     req,
    input  logic [VPN_W-1:0]         vpn,
    input  logic [ASID_W-1:0]        asid,
    input  logic [1:0]               acc,
    output logic                     hit,
    output logic                     miss,
    output logic [PFN_W-1:0]         pfn,
    output logic                     fault
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     match;
    logic [IDX_W-1:0] sel;
    logic             found;

    // R2 R3: per-entry tag compare
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ent[i].valid && (ent[i].vpn == vpn) &&
                          (ent[i].glob || (ent[i].asid == asid));
    end

    // R9: lowest index wins
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
    end

    assign found = |match;
    assign hit   = req && found;
    assign miss  = req && !found;
    assign pfn   = hit ? ent[sel].pfn : '0;
    assign fault = hit && !perm_allows(ent[sel].perm, acc_e'(acc));

    // R4
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> hit);

    // R1
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss) && ((hit || miss) -> req));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N = TLB_ENTRIES,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rf_en,
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     wired,
    input  logic [N-1:0]     same,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] slot,
    output logic             ok,
    output logic             replace
);
    logic [IDX_W-1:0] same_idx, free_idx, rr_idx, idx;
    logic             same_f, free_f, rr_f;

    always_comb begin
        same_idx = '0; same_f = 1'b0;
        free_idx = '0; free_f = 1'b0;
        rr_idx   = '0; rr_f   = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same[i]) begin
                same_idx = IDX_W'(i);
                same_f   = 1'b1;
            end
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_f   = 1'b1;
            end
        end
        // R6: rotating search from the pointer, skipping pinned slots
        for (int k = N - 1; k >= 0; k--) begin
            idx = ptr + IDX_W'(k);
            if (!wired[idx]) begin
                rr_idx = idx;
                rr_f   = 1'b1;
            end
        end
        replace = 1'b0;
        if (same_f) begin
            slot = same_idx; ok = 1'b1;
        end else if (free_f) begin
            slot = free_idx; ok = 1'b1;
        end else begin
            slot = rr_idx; ok = rr_f; replace = rr_f;
        end
    end

    // R6
    victim_unwired_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_en && replace) |-> (!wired[slot] && valid[slot]));

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N = TLB_ENTRIES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rf_en,
    input  tlb_entry_t         rf_ent,
    input  logic               fl_en,
    output tlb_entry_t [N-1:0] ent_q,
    output logic               rf_err
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     valid_v, wired_v, same_v;
    logic [IDX_W-1:0] ptr_q, slot;
    logic             ok, replace;

    for (genvar i = 0; i < N; i++) begin : g_vec
        assign valid_v[i] = ent_q[i].valid;
        assign wired_v[i] = ent_q[i].wired;
        // R5: in-place match on page and tag
        assign same_v[i]  = ent_q[i].valid && (ent_q[i].vpn == rf_ent.vpn) &&
                            (ent_q[i].asid == rf_ent.asid);
    end

    tlb_victim #(.N(N)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .rf_en   (rf_en),
        .valid   (valid_v),
        .wired   (wired_v),
        .same    (same_v),
        .ptr     (ptr_q),
        .slot    (slot),
        .ok      (ok),
        .replace (replace)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q  <= '0;
            ptr_q  <= '0;
            rf_err <= 1'b0;
        end else begin
            rf_err <= rf_en && !ok;
            if (fl_en) begin
                for (int i = 0; i < N; i++) begin
                    if (!ent_q[i].wired) ent_q[i].valid <= 1'b0;
                end
            end
            if (rf_en && ok) begin
                ent_q[slot] <= rf_ent;
                if (replace) ptr_q <= slot + IDX_W'(1);
            end
        end
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_en && !rf_en) |=> ((valid_v & ~wired_v) == '0));

    for (genvar i = 0; i < N; i++) begin : g_pin
        // R8
        pinned_survive_chk: assert property (@(posedge clk) disable iff (rst)
            (fl_en && !rf_en && ent_q[i].valid && ent_q[i].wired) |=> ent_q[i].valid);
    end

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = TLB_ENTRIES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_fault,
    input  logic              rf_en,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [2:0]        rf_perm,
    input  logic              rf_global,
    input  logic              rf_wired,
    input  logic              fl_en,
    output logic              rf_err
);
    tlb_entry_t [NUM_ENTRIES-1:0] ent;
    tlb_entry_t                   new_ent;
    logic [NUM_ENTRIES-1:0]       pinned_v;

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.glob  = rf_global;
        new_ent.wired = rf_wired;
        new_ent.asid  = rf_asid;
        new_ent.vpn   = rf_vpn;
        new_ent.pfn   = rf_pfn;
        new_ent.perm  = perm_t'(rf_perm);
    end

    tlb_store #(.N(NUM_ENTRIES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .rf_en  (rf_en),
        .rf_ent (new_ent),
        .fl_en  (fl_en),
        .ent_q  (ent),
        .rf_err (rf_err)
    );

    tlb_lookup #(.N(NUM_ENTRIES)) u_lookup (
        .clk   (clk),
        .rst   (rst),
        .ent   (ent),
        .req   (lk_req),
        .vpn   (lk_vpn),
        .asid  (lk_asid),
        .acc   (lk_acc),
        .hit   (lk_hit),
        .miss  (lk_miss),
        .pfn   (lk_pfn),
        .fault (lk_fault)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_pinned
        assign pinned_v[i] = ent[i].valid && ent[i].wired;
    end

    // R7
    drop_only_when_pinned_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_err && !$past(fl_en)) |-> (&pinned_v));

    // R1
    pfn_zero_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pfn == '0));

endmodule

// File: tb/tb_tlb_top.sv
module tb_tlb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_miss, lk_fault, rf_err;
    logic [19:0] lk_pfn;
    logic        rf_en = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic [19:0] rf_pfn = '0;
    logic [2:0]  rf_perm = '0;
    logic        rf_global = 1'b0;
    logic        rf_wired = 1'b0;
    logic        fl_en = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_valid [N];
    bit          m_glob  [N];
    bit          m_wired [N];
    logic [7:0]  m_asid  [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_pfn   [N];
    logic [2:0]  m_perm  [N];
    int          m_ptr = 0;
    bit          m_err = 0;

    always #5 clk = ~clk;

    tlb_top dut (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_fault(lk_fault),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn),
        .rf_perm(rf_perm), .rf_global(rf_global), .rf_wired(rf_wired),
        .fl_en(fl_en), .rf_err(rf_err)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare at mid-cycle, then clock and advance the model
    task automatic cyc(string tag);
        int  hi;
        bit  e_hit, e_miss, e_fault, allowed;
        int  e_pfn;
        int  slot;
        bit  repl;
        #3;
        hi = -1;
        for (int i = 0; i < N; i++)
            if (hi < 0 && m_valid[i] && m_vpn[i] == lk_vpn &&
                (m_glob[i] || m_asid[i] == lk_asid)) hi = i;
        e_hit = lk_req && hi >= 0;
        e_miss = lk_req && hi < 0;
        e_pfn = e_hit ? int'(m_pfn[hi]) : 0;
        allowed = 0;
        if (e_hit) begin
            if (lk_acc == 2'd0) allowed = m_perm[hi][0];
            else if (lk_acc == 2'd1) allowed = m_perm[hi][1];
            else if (lk_acc == 2'd2) allowed = m_perm[hi][2];
        end
        e_fault = e_hit && !allowed;
        chk(tag, "lk_hit", int'(lk_hit), int'(e_hit));
        chk(tag, "lk_miss", int'(lk_miss), int'(e_miss));
        chk(tag, "lk_pfn", int'(lk_pfn), e_pfn);
        chk(tag, "lk_fault", int'(lk_fault), int'(e_fault));
        chk(tag, "rf_err", int'(rf_err), int'(m_err));
        @(posedge clk);
        slot = -1; repl = 0;
        for (int i = 0; i < N; i++)
            if (slot < 0 && m_valid[i] && m_vpn[i] == rf_vpn && m_asid[i] == rf_asid) slot = i;
        for (int i = 0; i < N; i++)
            if (slot < 0 && !m_valid[i]) slot = i;
        for (int k = 0; k < N; k++)
            if (slot < 0 && !m_wired[(m_ptr + k) % N]) begin
                slot = (m_ptr + k) % N; repl = 1;
            end
        m_err = rf_en && slot < 0;
        if (fl_en)
            for (int i = 0; i < N; i++) if (!m_wired[i]) m_valid[i] = 0;
        if (rf_en && slot >= 0) begin
            m_valid[slot] = 1; m_glob[slot] = rf_global; m_wired[slot] = rf_wired;
            m_asid[slot] = rf_asid; m_vpn[slot] = rf_vpn; m_pfn[slot] = rf_pfn;
            m_perm[slot] = rf_perm;
            if (repl) m_ptr = (slot + 1) % N;
        end
        #1;
    endtask

    task automatic look(logic [19:0] v, logic [7:0] a, logic [1:0] acc, string tag);
        lk_req = 1; lk_vpn = v; lk_asid = a; lk_acc = acc;
        cyc(tag);
    endtask

    task automatic refill(logic [19:0] v, logic [7:0] a, logic [19:0] p, logic [2:0] pm,
                          bit g, bit w, string tag);
        rf_en = 1; rf_vpn = v; rf_asid = a; rf_pfn = p; rf_perm = pm;
        rf_global = g; rf_wired = w;
        cyc(tag);
        rf_en = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R3: empty after reset, no request gives nothing
        look(20'h100, 8'd1, 2'd0, "R3");
        lk_req = 0; cyc("R1");

        // R5: fill free slots in order
        for (int i = 0; i < N; i++) begin
            logic [2:0] pm;
            pm = (i % 4 == 0) ? 3'b001 : (i % 4 == 1) ? 3'b011 :
                 (i % 4 == 2) ? 3'b101 : 3'b111;
            refill(20'h100 + 20'(i), 8'd1, 20'hA000 + 20'(i), pm, i == 7, i == 1 || i == 2, "R5");
        end
        for (int i = 0; i < N; i++) look(20'h100 + 20'(i), 8'd1, 2'd0, "R1");

        // R2: tag mismatch misses, global matches anything
        look(20'h100, 8'd2, 2'd0, "R2");
        look(20'h107, 8'd9, 2'd0, "R2");
        look(20'h999, 8'd1, 2'd0, "R1");

        // R4: permission faults
        look(20'h100, 8'd1, 2'd1, "R4");
        look(20'h100, 8'd1, 2'd2, "R4");
        look(20'h101, 8'd1, 2'd1, "R4");
        look(20'h101, 8'd1, 2'd2, "R4");
        look(20'h102, 8'd1, 2'd2, "R4");
        look(20'h103, 8'd1, 2'd3, "R4");

        // R5: in-place update
        refill(20'h103, 8'd1, 20'hBEEF, 3'b111, 0, 0, "R5");
        look(20'h103, 8'd1, 2'd0, "R5");

        // R6: round robin skipping pinned slots
        refill(20'h200, 8'd1, 20'hC200, 3'b111, 0, 0, "R6");
        refill(20'h201, 8'd1, 20'hC201, 3'b111, 0, 0, "R6");
        look(20'h100, 8'd1, 2'd0, "R6");
        look(20'h200, 8'd1, 2'd0, "R6");
        look(20'h201, 8'd1, 2'd0, "R6");
        look(20'h103, 8'd1, 2'd0, "R6");
        look(20'h101, 8'd1, 2'd0, "R6");

        // R9: two matches, lowest index wins
        refill(20'h107, 8'd2, 20'hD107, 3'b001, 0, 0, "R9");
        look(20'h107, 8'd2, 2'd1, "R9");
        look(20'h107, 8'd1, 2'd1, "R9");

        // R8: flush keeps pinned entries
        fl_en = 1; cyc("R8"); fl_en = 0;
        look(20'h101, 8'd1, 2'd0, "R8");
        look(20'h200, 8'd1, 2'd0, "R8");
        look(20'h107, 8'd2, 2'd0, "R8");
        fl_en = 1;
        refill(20'h300, 8'd3, 20'hE300, 3'b011, 0, 0, "R8");
        fl_en = 0;
        look(20'h300, 8'd3, 2'd0, "R8");

        // R7: make everything pinned, then drop a refill
        for (int k = 0; k < 5; k++)
            refill(20'h400 + 20'(k), 8'd4, 20'hF400 + 20'(k), 3'b111, 0, 1, "R7");
        refill(20'h4FF, 8'd4, 20'hF4FF, 3'b111, 0, 1, "R7");
        look(20'h300, 8'd3, 2'd0, "R7");
        refill(20'h500, 8'd5, 20'hF500, 3'b111, 0, 0, "R7");
        look(20'h500, 8'd5, 2'd0, "R7");
        look(20'h4FF, 8'd4, 2'd0, "R7");
        refill(20'h101, 8'd1, 20'h1234, 3'b001, 0, 1, "R5");
        look(20'h101, 8'd1, 2'd0, "R5");
        fl_en = 1; cyc("R8"); fl_en = 0;
        look(20'h400, 8'd4, 2'd2, "R8");
        lk_req = 0; cyc("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule